// File: doc/BRIEF.md
# Implication-based concurrent assertion checker

This block sits beside a combinational control circuit and judges, in the same cycle, whether the circuit's input vector and output vector agree with a fixed set of implication rules. Each rule says: when a selected group of inputs holds a given pattern, one named output must carry a given value. A rule whose input pattern is not present places no constraint on anything. The block does not predict the whole truth table. It checks only the part that the rules cover, so its cost follows the number of rules and not the width of the circuit.

The rules are set at elaboration time through parameter vectors: a care mask and a pattern over the input width, an output index, and a required polarity for each rule. The combined verdict is the AND of all rules. It comes out as a dual-rail pair that a downstream checker can watch for internal faults. A registered error flag records any violation until software-free logic upstream clears it. A self-exercising test sequencer drives every rule, one per cycle, into its own violating condition, and confirms that exactly that rule, and no other, reports it.

Top module: `impl_checker`

## Requirements
- R1: Rule k's antecedent is true when every input bit selected by its care mask equals the matching bit of its pattern. Input bits outside the mask do not matter. A rule reports a violation only when its antecedent is true and its consequent is false. With the antecedent false, any output value passes.
- R2: Rule k's consequent is true when output bit `OUT_SEL[k]` equals polarity bit `CONS_POL[k]`: 1 needs a high output, 0 needs a low output.
- R3: `hit_vec[k]` is 1 in the same cycle, with no register, exactly when rule k is violated by the vectors the checker is judging.
- R4: `chk_rail` is 2'b10 when no rule is violated and 2'b01 when one or more are, combinationally in the same cycle. 2'b00 and 2'b11 never appear on a healthy checker.
- R5: `err_flag` becomes 1 at the clock edge that ends a non-test cycle in which `chk_rail` was not 2'b10. It then stays 1 until an edge with `err_clear` high and no new violation. A violation in the same cycle as a clear leaves the flag at 1.
- R6: While `rst` is high, `err_flag`, `test_busy`, `test_done` and `test_fail` are 0 after the clock edge.
- R7: A `test_start` pulse while the sequencer is not busy raises `test_busy` from the next cycle. For N cycles the checker then judges forced vectors in place of `ctl_in` and `ctl_out`, one rule per cycle in order 0 to N-1. In each of these cycles the selected rule's antecedent is true and its consequent false, so a healthy set shows `hit_vec` equal to one bit at the rule's position and `chk_rail` equal to 2'b01. `test_start` has no effect while busy.
- R8: After the Nth test cycle, `test_busy` falls and `test_done` rises. `test_done` is held until the next accepted `test_start`. `test_fail` is set if any test cycle showed a `hit_vec` other than its own single bit, or a `chk_rail` other than 2'b01. The test run never sets `err_flag`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ctl_in | input | IN_W | Input vector of the protected circuit |
| ctl_out | input | OUT_W | Output vector of the protected circuit |
| err_clear | input | 1 | Synchronous clear of the sticky error flag |
| test_start | input | 1 | Pulse that starts the self-exercising run |
| chk_rail | output | 2 | Dual-rail verdict: 10 pass, 01 violation |
| hit_vec | output | N_AST | Per-rule violation indicators |
| err_flag | output | 1 | Sticky registered error flag |
| test_busy | output | 1 | Self-exercising run in progress |
| test_done | output | 1 | Self-exercising run finished |
| test_fail | output | 1 | Self-exercising run found a missing or stray violation |

## Verification
The bench aims at rules whose antecedent is absent while the output is far from the rule's value. A checker that ignored the care mask, or tested only the consequent, would flag those rows. It also drives vectors that break several rules at once, and rules of both polarities. A swapped polarity or a wrong output index would show up as a wrong `hit_vec` bit. The sticky flag is checked where a violation and a clear arrive together, where the wrong priority would drop the event. The test run is checked with deliberately violating port values present: leaking them past the force path, honouring a restart while busy, or letting the run set `err_flag` would each change the sampled outputs. A second instance with two identical rules must end its test run with `test_fail`. A sequencer that checks only its own bit would pass it.

// File: rtl/ic_pkg.sv
package ic_pkg;

    // Dual-rail verdict: t carries "all rules hold", f carries "some rule broke".
    typedef struct packed {
        logic t;
        logic f;
    } rail_t;

    localparam rail_t RAIL_PASS = '{t: 1'b1, f: 1'b0};
    localparam rail_t RAIL_VIOL = '{t: 1'b0, f: 1'b1};

    typedef enum logic [1:0] {
        SQ_IDLE = 2'd0,
        SQ_RUN  = 2'd1,
        SQ_DONE = 2'd2
    } seq_state_e;

    // Dual-rail AND: pass only when both pass; fail when either fails.
    function automatic rail_t rail_and(input rail_t a, input rail_t b);
        rail_t z;
        z.t = a.t & b.t;
        z.f = a.f | b.f;
        return z;
    endfunction

endpackage

// File: rtl/ic_term_eval.sv
module ic_term_eval
    import ic_pkg::*;
#(
    parameter int unsigned   IN_W  = 8,
    parameter int unsigned   OUT_W = 8,
    parameter logic [IN_W-1:0] CARE = '0,
    parameter logic [IN_W-1:0] PAT  = '0,
    parameter int unsigned   OSEL  = 0,
    parameter logic          POL   = 1'b1
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [IN_W-1:0]  vin,
    input  logic [OUT_W-1:0] vout,
    output rail_t            rail
);

    logic [IN_W-1:0] diff;
    logic ant_true;
    logic ant_miss;
    logic lit_ok;
    logic lit_bad;

    always_comb begin
        diff     = (vin ^ PAT) & CARE;
        // The two antecedent rails come from separate reductions.
        ant_true = (diff == '0);
        ant_miss = |diff;
        lit_ok   = (vout[OSEL] == POL);
        lit_bad  = vout[OSEL] ^ POL;
        rail.t   = ant_miss | lit_ok;
        rail.f   = ant_true & lit_bad;
    end

    AST_TERM_RAIL_VALID: assert property (@(posedge clk) disable iff (rst)
        rail.t != rail.f) else $error("term rail not complementary"); // R1

endmodule

// File: rtl/ic_rail_join.sv
module ic_rail_join
    import ic_pkg::*;
#(
    parameter int unsigned N_AST = 4
) (
    input  logic                clk,
    input  logic                rst,
    input  rail_t [N_AST-1:0]   rails,
    output rail_t               joined
);

    always_comb begin
        joined = RAIL_PASS;
        for (int k = 0; k < N_AST; k++) begin
            joined = rail_and(joined, rails[k]);
        end
    end

    AST_JOIN_RAIL_VALID: assert property (@(posedge clk) disable iff (rst)
        joined.t != joined.f) else $error("joined rail invalid"); // R4

endmodule

// File: rtl/ic_test_seq.sv
module ic_test_seq
    import ic_pkg::*;
#(
    parameter int unsigned IN_W  = 8,
    parameter int unsigned OUT_W = 8,
    parameter int unsigned N_AST = 4,
    parameter logic [N_AST*IN_W-1:0] ANT_CARE = '0,
    parameter logic [N_AST*IN_W-1:0] ANT_PAT  = '0,
    parameter logic [N_AST*8-1:0]    OUT_SEL  = '0,
    parameter logic [N_AST-1:0]      CONS_POL = '0
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             test_start,
    input  logic [N_AST-1:0] hit_vec,
    input  rail_t            verdict,
    output logic             busy,
    output logic             done,
    output logic             fail,
    output logic [IN_W-1:0]  force_in,
    output logic [OUT_W-1:0] force_out
);

    localparam int unsigned IDX_W = (N_AST > 1) ? $clog2(N_AST) : 1;
    localparam logic [IDX_W-1:0] LAST = IDX_W'(N_AST - 1);

    seq_state_e       state;
    logic [IDX_W-1:0] idx;
    logic             step_bad;

    // Forced vectors: chosen rule's pattern on the inputs, its output inverted,
    // and other outputs set so that rules sharing the input satisfy theirs.
    always_comb begin
        force_in  = '0;
        force_out = '0;
        for (int j = 0; j < N_AST; j++) begin
            if (IDX_W'(j) == idx) begin
                force_in = ANT_PAT[j*IN_W +: IN_W] & ANT_CARE[j*IN_W +: IN_W];
            end
        end
        for (int j = 0; j < N_AST; j++) begin
            if (IDX_W'(j) != idx &&
                (((force_in ^ ANT_PAT[j*IN_W +: IN_W]) & ANT_CARE[j*IN_W +: IN_W]) == '0)) begin
                for (int b = 0; b < OUT_W; b++) begin
                    if (OUT_SEL[j*8 +: 8] == 8'(b)) force_out[b] = force_out[b] | CONS_POL[j];
                end
            end
        end
        for (int j = 0; j < N_AST; j++) begin
            if (IDX_W'(j) == idx) begin
                for (int b = 0; b < OUT_W; b++) begin
                    if (OUT_SEL[j*8 +: 8] == 8'(b)) force_out[b] = ~CONS_POL[j];
                end
            end
        end
    end

    always_comb begin
        step_bad = (hit_vec != (N_AST'(1) << idx)) || (verdict != RAIL_VIOL);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state <= SQ_IDLE;
            idx   <= '0;
            fail  <= 1'b0;
        end else begin
            unique case (state)
                SQ_RUN: begin
                    if (step_bad) fail <= 1'b1;
                    if (idx == LAST) state <= SQ_DONE;
                    else             idx   <= idx + 1'b1;
                end
                default: begin
                    if (test_start) begin
                        state <= SQ_RUN;
                        idx   <= '0;
                        fail  <= 1'b0;
                    end
                end
            endcase
        end
    end

    assign busy = (state == SQ_RUN);
    assign done = (state == SQ_DONE);

    AST_START_IDLE: assert property (@(posedge clk) disable iff (rst)
        test_start && !busy |=> busy) else $error("start not accepted"); // R7
    AST_BUSY_DONE_EXCL: assert property (@(posedge clk) disable iff (rst)
        !(busy && done)) else $error("busy and done together"); // R8
    AST_RUN_ENDS: assert property (@(posedge clk) disable iff (rst)
        busy && idx == LAST |=> done && !busy) else $error("run did not end"); // R8

endmodule

// File: rtl/impl_checker.sv
module impl_checker
    import ic_pkg::*;
#(
    parameter int unsigned IN_W  = 8,
    parameter int unsigned OUT_W = 8,
    parameter int unsigned N_AST = 4,
    parameter logic [N_AST*IN_W-1:0] ANT_CARE = {8'h10, 8'hC0, 8'h01, 8'h0C},
    parameter logic [N_AST*IN_W-1:0] ANT_PAT  = {8'h00, 8'hC0, 8'h01, 8'h04},
    parameter logic [N_AST*8-1:0]    OUT_SEL  = {8'd0, 8'd3, 8'd1, 8'd5},
    parameter logic [N_AST-1:0]      CONS_POL = 4'b0101
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [IN_W-1:0]  ctl_in,
    input  logic [OUT_W-1:0] ctl_out,
    input  logic             err_clear,
    input  logic             test_start,
    output logic [1:0]       chk_rail,
    output logic [N_AST-1:0] hit_vec,
    output logic             err_flag,
    output logic             test_busy,
    output logic             test_done,
    output logic             test_fail
);

    logic [IN_W-1:0]  force_in;
    logic [OUT_W-1:0] force_out;
    logic [IN_W-1:0]  judge_in;
    logic [OUT_W-1:0] judge_out;
    rail_t [N_AST-1:0] term_rail;
    rail_t            verdict;

    assign judge_in  = test_busy ? force_in  : ctl_in;
    assign judge_out = test_busy ? force_out : ctl_out;

    for (genvar k = 0; k < N_AST; k++) begin : g_term
        ic_term_eval #(
            .IN_W (IN_W),
            .OUT_W(OUT_W),
            .CARE (ANT_CARE[k*IN_W +: IN_W]),
            .PAT  (ANT_PAT[k*IN_W +: IN_W]),
            .OSEL (int'(OUT_SEL[k*8 +: 8])),
            .POL  (CONS_POL[k])
        ) u_term (
            .clk (clk),
            .rst (rst),
            .vin (judge_in),
            .vout(judge_out),
            .rail(term_rail[k])
        );
        assign hit_vec[k] = term_rail[k].f;
    end

    ic_rail_join #(.N_AST(N_AST)) u_join (
        .clk   (clk),
        .rst   (rst),
        .rails (term_rail),
        .joined(verdict)
    );

    assign chk_rail = verdict;

    ic_test_seq #(
        .IN_W    (IN_W),
        .OUT_W   (OUT_W),
        .N_AST   (N_AST),
        .ANT_CARE(ANT_CARE),
        .ANT_PAT (ANT_PAT),
        .OUT_SEL (OUT_SEL),
        .CONS_POL(CONS_POL)
    ) u_seq (
        .clk       (clk),
        .rst       (rst),
        .test_start(test_start),
        .hit_vec   (hit_vec),
        .verdict   (verdict),
        .busy      (test_busy),
        .done      (test_done),
        .fail      (test_fail),
        .force_in  (force_in),
        .force_out (force_out)
    );

    // Sticky error: a new violation outranks a clear in the same cycle.
    always_ff @(posedge clk) begin
        if (rst)                                   err_flag <= 1'b0;
        else if (!test_busy && verdict != RAIL_PASS) err_flag <= 1'b1;
        else if (err_clear)                        err_flag <= 1'b0;
    end

    AST_ERR_SET: assert property (@(posedge clk) disable iff (rst)
        !test_busy && chk_rail != 2'b10 |=> err_flag) else $error("violation not latched"); // R5
    AST_ERR_STICKY: assert property (@(posedge clk) disable iff (rst)
        err_flag && !err_clear |=> err_flag) else $error("error flag dropped"); // R5
    AST_ERR_FROZEN_IN_TEST: assert property (@(posedge clk) disable iff (rst)
        test_busy && !err_flag |=> !err_flag) else $error("test run set error"); // R8

endmodule

// File: tb/tb_impl_checker.sv
module tb_impl_checker;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [7:0] ctl_in = 8'h04;
    logic [7:0] ctl_out = 8'h20;
    logic       err_clear = 1'b0;
    logic       test_start = 1'b0;
    logic       test_start2 = 1'b0;
    logic [1:0] chk_rail, chk_rail2;
    logic [3:0] hit_vec;
    logic [1:0] hit_vec2;
    logic       err_flag, test_busy, test_done, test_fail;
    logic       err_flag2, test_busy2, test_done2, test_fail2;

    int checks = 0;
    int errors = 0;
    bit finished = 1'b0;

    always #2 clk = ~clk;

    impl_checker dut (
        .clk(clk), .rst(rst), .ctl_in(ctl_in), .ctl_out(ctl_out),
        .err_clear(err_clear), .test_start(test_start),
        .chk_rail(chk_rail), .hit_vec(hit_vec), .err_flag(err_flag),
        .test_busy(test_busy), .test_done(test_done), .test_fail(test_fail)
    );

    // Two identical rules: each forced violation also breaks the twin.
    impl_checker #(
        .N_AST(2),
        .ANT_CARE({8'h0C, 8'h0C}),
        .ANT_PAT ({8'h04, 8'h04}),
        .OUT_SEL ({8'd5, 8'd5}),
        .CONS_POL(2'b11)
    ) dut_twin (
        .clk(clk), .rst(rst), .ctl_in(ctl_in), .ctl_out(ctl_out),
        .err_clear(err_clear), .test_start(test_start2),
        .chk_rail(chk_rail2), .hit_vec(hit_vec2), .err_flag(err_flag2),
        .test_busy(test_busy2), .test_done(test_done2), .test_fail(test_fail2)
    );

    // Rows: {ctl_in, ctl_out, expected hit_vec (low nibble)}.
    // Rules: 0: in2=1,in3=0 -> out5=1; 1: in0=1 -> out1=0;
    //        2: in7=1,in6=1 -> out3=1; 3: in4=0 -> out0=0.
    localparam logic [23:0] TBL [10] = '{
        {8'h04, 8'h20, 8'h00},
        {8'h04, 8'h00, 8'h01},
        {8'h0C, 8'h00, 8'h00},
        {8'h01, 8'h02, 8'h02},
        {8'hC0, 8'h00, 8'h04},
        {8'hC0, 8'h08, 8'h00},
        {8'h00, 8'h01, 8'h08},
        {8'h10, 8'hFF, 8'h00},
        {8'hC5, 8'h01, 8'h0D},
        {8'hC5, 8'h28, 8'h00}
    };

    task automatic check(input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1'b1;
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        logic acc;
        repeat (3) @(negedge clk);
        check("R6", "err_flag in reset", 32'(err_flag), 0);
        check("R6", "test_busy in reset", 32'(test_busy), 0);
        check("R6", "test_done in reset", 32'(test_done), 0);
        check("R6", "test_fail in reset", 32'(test_fail), 0);
        rst = 1'b0;
        err_clear = 1'b1;
        @(negedge clk);
        err_clear = 1'b0;
        check("R5", "flag clear after clean clear", 32'(err_flag), 0);

        // Table walk: per-rule hits, rail and sticky flag.
        acc = 1'b0;
        for (int r = 0; r < 10; r++) begin
            ctl_in  = TBL[r][23:16];
            ctl_out = TBL[r][15:8];
            #1;
            check("R1 R2 R3", $sformatf("hit_vec row %0d", r), 32'(hit_vec), 32'(TBL[r][3:0]));
            check("R4", $sformatf("chk_rail row %0d", r), 32'(chk_rail),
                  (TBL[r][3:0] == 4'h0) ? 32'h2 : 32'h1);
            acc = acc | (TBL[r][3:0] != 4'h0);
            @(negedge clk);
            check("R5", $sformatf("err_flag row %0d", r), 32'(err_flag), 32'(acc));
        end

        // Sticky flag corner cases.
        ctl_in = 8'h04; ctl_out = 8'h20; err_clear = 1'b1;
        @(negedge clk);
        check("R5", "clear with clean vector", 32'(err_flag), 0);
        ctl_out = 8'h00;
        @(negedge clk);
        check("R5", "violation beats clear", 32'(err_flag), 1);
        ctl_out = 8'h20; err_clear = 1'b0;
        @(negedge clk);
        @(negedge clk);
        check("R5", "flag held without clear", 32'(err_flag), 1);
        err_clear = 1'b1;
        @(negedge clk);
        err_clear = 1'b0;
        check("R5", "flag cleared", 32'(err_flag), 0);

        // Self-exercising run with violating port values present.
        test_start = 1'b1;
        @(negedge clk);
        test_start = 1'b0;
        ctl_in = 8'h04; ctl_out = 8'h00;
        for (int k = 0; k < 4; k++) begin
            check("R7", $sformatf("busy step %0d", k), 32'(test_busy), 1);
            check("R7", $sformatf("forced hit step %0d", k), 32'(hit_vec), 32'(1) << k);
            check("R7", $sformatf("forced rail step %0d", k), 32'(chk_rail), 32'h1);
            if (k == 1) test_start = 1'b1;
            @(negedge clk);
            test_start = 1'b0;
        end
        check("R8", "done after run", 32'(test_done), 1);
        check("R8", "busy after run", 32'(test_busy), 0);
        check("R8", "fail on healthy rules", 32'(test_fail), 0);
        check("R8", "test run left err_flag", 32'(err_flag), 0);
        ctl_out = 8'h20;
        repeat (3) @(negedge clk);
        check("R8", "done held", 32'(test_done), 1);

        // Twin rules: the sequencer must notice the stray violation.
        test_start2 = 1'b1;
        @(negedge clk);
        test_start2 = 1'b0;
        check("R7", "twin busy", 32'(test_busy2), 1);
        repeat (2) @(negedge clk);
        check("R8", "twin done", 32'(test_done2), 1);
        check("R8", "twin stray violation flagged", 32'(test_fail2), 1);
        test_start2 = 1'b1;
        @(negedge clk);
        test_start2 = 1'b0;
        check("R8", "restart clears done", 32'(test_done2), 0);
        check("R8", "restart clears fail", 32'(test_fail2), 0);
        repeat (2) @(negedge clk);
        check("R8", "twin fail again", 32'(test_fail2), 1);

        finish_run();
    end

endmodule